// File: doc/BRIEF.md
# Register-Driven One-Wire Bus Master

This block runs the lowest layer of the 1-Wire protocol for a processor on a simple 32-bit register bus. Each operation is one of two kinds: a bus reset that also detects a presence pulse, or a single bit slot. Software chooses the line, the operation, the speed and the bit in one control/status word, and the same write starts the operation. Software then polls a busy flag until the flag clears, and reads back the level that was sampled. Byte assembly, ROM commands and device protocols are left to software.

All slot timing counts in ticks. A prescaler makes the ticks, and its reload value comes from one of two 16-bit fields: one for normal speed and one for overdrive. With one tick per microsecond, the default phase lengths match standard 1-Wire timing. The lines are open-drain. The master only pulls a line low or lets it go. Each line also has a strong-pullup enable, which is forced off whenever that line is pulled low. An interrupt flag can be raised when an operation ends.

Top module: `owb_master`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0 and the divider word (offset 0x4) reads 0x003E_0138. No line is pulled low, no strong pullup is on and `irq` is low.
- R2: The control word holds these fields: bit 0 data, bit 1 reset-operation select, bit 2 overdrive, bit 3 start/busy, bit 4 strong pullup for the selected line, bit 6 interrupt flag, bit 7 interrupt enable, bits 11:8 line select, bits 31:16 per-line pullup enables. Bits 5 and 15:12 read 0. The divider word reads back as written: normal reload in bits 15:0, overdrive reload in bits 31:16.
- R3: A control write with bit 3 set starts an operation. Bit 3 reads 1 from the cycle after that write until the operation ends, then clears itself. One tick lasts reload+1 clocks. A bit slot lasts 70 ticks and a reset operation lasts 960 ticks.
- R4: In a bit slot the selected line is pulled low for 6 ticks when the data bit is 1 and for 60 ticks when it is 0.
- R5: In a bit slot the line level is captured at the end of tick 15 of the slot, after a 2-clock input synchronizer. That level then reads back in bit 0, so writing 1 performs a read slot.
- R6: A reset operation pulls the line low for 480 ticks and samples 70 ticks after the release. Bit 0 then reads 0 if a device held the line low (presence) and 1 otherwise.
- R7: While bit 2 is set, ticks use the overdrive reload (bits 31:16). While it is clear, ticks use the normal reload (bits 15:0).
- R8: Only the line named by bits 11:8 is ever pulled low, and only that line is sampled. A select value of 4 or more (beyond the line count) drives no line and reads back 1.
- R9: No line is pulled low while no operation is running.
- R10: Line p's strong pullup is on when enable bit 16+p is set, or when bit 4 is set and line p is selected. It is off in every cycle in which line p is pulled low.
- R11: When an operation ends with bit 7 set, bit 6 and `irq` go to 1. They return to 0 on the next accepted control write. With bit 7 clear they stay 0.
- R12: While an operation runs, writes to either register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte address: 0x0 control word, 0x4 divider word |
| bus_wen | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt flag |
| line_pull_low | output | 4 | Per-line open-drain pull-down enable |
| line_pwr | output | 4 | Per-line strong-pullup enable |
| line_in | input | 4 | Per-line sensed level |

## Verification
Busy rises in the cycle after the write edge and stays high for exactly ticks × (reload+1) clocks. The pull-low window starts in that same cycle and lasts the phase length times reload+1. The bench counts both windows from the middle of the first cycle after the write, so a one-clock error in either edge changes the count. The sample point is tested by releasing a held-low line at clock 12 or 13 after the write, with reload 0. Those two clocks straddle the tick-15 capture once the 2-stage synchronizer is counted, so the first must read 1 and the second 0. Read-back data, the interrupt flag and the ignored writes are checked only after busy has cleared.

// File: rtl/owb_pkg.sv
package owb_pkg;
   localparam int REG_W    = 32;
   localparam int DIV_W    = 16;
   localparam int SEL_W    = 4;

   // control word bit positions
   localparam int B_DAT    = 0;
   localparam int B_RST    = 1;
   localparam int B_OVD    = 2;
   localparam int B_CYC    = 3;
   localparam int B_SPU    = 4;
   localparam int B_IEN    = 7;
   localparam int B_SEL_LO = 8;
   localparam int B_PWR_LO = 16;

   localparam logic [2:0] OFS_CTRL = 3'h0;
   localparam logic [2:0] OFS_DIV  = 3'h4;

   typedef struct packed {
      logic [15:0]      pwr_en;
      logic [SEL_W-1:0] sel;
      logic             ien;
      logic             spu;
      logic             ovd;
      logic             rst;
      logic             dat;
   } owb_ctrl_t;
endpackage

// File: rtl/owb_tick_gen.sv
module owb_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] reload,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == reload);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/owb_slot_fsm.sv
module owb_slot_fsm #(
   parameter int RST_LOW  = 480,
   parameter int RST_SMP  = 550,
   parameter int RST_END  = 960,
   parameter int BIT_LOW1 = 6,
   parameter int BIT_LOW0 = 60,
   parameter int BIT_SMP  = 15,
   parameter int BIT_END  = 70
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_reset,
   input  logic wr_bit,
   input  logic tick,
   input  logic line_level,
   output logic busy,
   output logic drive_low,
   output logic done,
   output logic smp_bit
);
   localparam int MAX_T = (RST_END > BIT_END) ? RST_END : BIT_END;
   localparam int CNT_W = $clog2(MAX_T + 1);

   if (BIT_SMP >= BIT_END || BIT_LOW0 >= BIT_END || BIT_LOW1 > BIT_SMP) begin : g_bad_bit
      $error("owb_slot_fsm: bit slot phases out of order");
   end
   if (RST_SMP <= RST_LOW || RST_SMP >= RST_END) begin : g_bad_rst
      $error("owb_slot_fsm: reset phases out of order");
   end

   logic             busy_q, rst_q, bit_q, smp_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] low_len, smp_at, end_at;

   always_comb begin
      if (rst_q) begin
         low_len = CNT_W'(RST_LOW);
         smp_at  = CNT_W'(RST_SMP);
         end_at  = CNT_W'(RST_END);
      end else begin
         low_len = bit_q ? CNT_W'(BIT_LOW1) : CNT_W'(BIT_LOW0);
         smp_at  = CNT_W'(BIT_SMP);
         end_at  = CNT_W'(BIT_END);
      end
   end

   assign busy      = busy_q;
   assign drive_low = busy_q && (cnt_q < low_len);
   assign done      = busy_q && tick && (cnt_q == end_at - 1'b1);
   assign smp_bit   = smp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rst_q  <= 1'b0;
         bit_q  <= 1'b0;
         smp_q  <= 1'b1;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         rst_q  <= is_reset;
         bit_q  <= wr_bit;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == smp_at - 1'b1) smp_q <= line_level;
         if (done) busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/owb_port_io.sv
module owb_port_io #(
   parameter int NPORTS      = 4,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic              drive_low,
   input  logic              spu,
   input  logic [NPORTS-1:0] pwr_en,
   input  logic [NPORTS-1:0] line_in,
   output logic [NPORTS-1:0] line_pull_low,
   output logic [NPORTS-1:0] line_pwr,
   output logic              level
);
   logic [NPORTS-1:0] line_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = line_in;
   end else begin : g_sync
      logic [NPORTS-1:0] st_q [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) st_q[i] <= '1;
         end else begin
            st_q[0] <= line_in;
            for (int i = 1; i < SYNC_STAGES; i++) st_q[i] <= st_q[i-1];
         end
      end
      assign line_s = st_q[SYNC_STAGES-1];
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_line
      logic hit;
      assign hit              = (sel == SEL_W'(p));
      assign line_pull_low[p] = drive_low & hit;
      assign line_pwr[p]      = (pwr_en[p] | (spu & hit)) & ~line_pull_low[p];
   end

   always_comb begin
      level = 1'b1;
      for (int p = 0; p < NPORTS; p++)
         if (sel == SEL_W'(p)) level = line_s[p];
   end
endmodule

// File: rtl/owb_master.sv
module owb_master
   import owb_pkg::*;
#(
   parameter int          NPORTS          = 4,
   parameter int          SYNC_STAGES     = 2,
   parameter int          ADDR_W          = 3,
   parameter logic [15:0] NOR_DIV_RST     = 16'd312,
   parameter logic [15:0] OVD_DIV_RST     = 16'd62,
   parameter int          RST_LOW_TICKS   = 480,
   parameter int          RST_PRES_TICKS  = 70,
   parameter int          RST_RECOV_TICKS = 480,
   parameter int          BIT_LOW1_TICKS  = 6,
   parameter int          BIT_LOW0_TICKS  = 60,
   parameter int          BIT_SMP_TICKS   = 15,
   parameter int          BIT_END_TICKS   = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic [NPORTS-1:0] line_pull_low,
   output logic [NPORTS-1:0] line_pwr,
   input  logic [NPORTS-1:0] line_in
);
   localparam int RST_SMP = RST_LOW_TICKS + RST_PRES_TICKS;
   localparam int RST_END = RST_LOW_TICKS + RST_RECOV_TICKS;

   if (NPORTS < 1 || NPORTS > 16) begin : g_bad_ports
      $error("owb_master: NPORTS must be 1..16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("owb_master: ADDR_W must be at least 3");
   end
   if (RST_PRES_TICKS >= RST_RECOV_TICKS) begin : g_bad_pres
      $error("owb_master: presence sample must precede end of reset");
   end

   owb_ctrl_t         ctrl_q;
   logic [REG_W-1:0]  div_q;
   logic              irq_q;
   logic              busy, drive_low, done, smp_bit, tick, level;
   logic              hit_ctrl, hit_div, accept_ctrl, accept_div, start;
   logic [DIV_W-1:0]  reload;

   assign hit_ctrl    = bus_wen && (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_div     = bus_wen && (bus_addr == ADDR_W'(OFS_DIV));
   assign accept_ctrl = hit_ctrl && !busy;
   assign accept_div  = hit_div && !busy;
   assign start       = accept_ctrl && bus_wdata[B_CYC];
   assign reload      = ctrl_q.ovd ? div_q[31:16] : div_q[15:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         div_q  <= {OVD_DIV_RST, NOR_DIV_RST};
         irq_q  <= 1'b0;
      end else begin
         if (accept_div) div_q <= bus_wdata;
         if (accept_ctrl) begin
            ctrl_q.pwr_en <= bus_wdata[B_PWR_LO +: 16];
            ctrl_q.sel    <= bus_wdata[B_SEL_LO +: SEL_W];
            ctrl_q.ien    <= bus_wdata[B_IEN];
            ctrl_q.spu    <= bus_wdata[B_SPU];
            ctrl_q.ovd    <= bus_wdata[B_OVD];
            ctrl_q.rst    <= bus_wdata[B_RST];
            ctrl_q.dat    <= bus_wdata[B_DAT];
            irq_q         <= 1'b0;
         end else if (done) begin
            ctrl_q.dat <= smp_bit;
            if (ctrl_q.ien) irq_q <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL))
         bus_rdata = {ctrl_q.pwr_en, 4'b0, ctrl_q.sel, ctrl_q.ien, irq_q, 1'b0,
                      ctrl_q.spu, busy, ctrl_q.ovd, ctrl_q.rst, ctrl_q.dat};
      else if (bus_addr == ADDR_W'(OFS_DIV))
         bus_rdata = div_q;
   end

   assign irq = irq_q;

   owb_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start),
      .reload  (reload),
      .tick    (tick)
   );

   owb_slot_fsm #(
      .RST_LOW  (RST_LOW_TICKS),
      .RST_SMP  (RST_SMP),
      .RST_END  (RST_END),
      .BIT_LOW1 (BIT_LOW1_TICKS),
      .BIT_LOW0 (BIT_LOW0_TICKS),
      .BIT_SMP  (BIT_SMP_TICKS),
      .BIT_END  (BIT_END_TICKS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_reset   (bus_wdata[B_RST]),
      .wr_bit     (bus_wdata[B_DAT]),
      .tick       (tick),
      .line_level (level),
      .busy       (busy),
      .drive_low  (drive_low),
      .done       (done),
      .smp_bit    (smp_bit)
   );

   owb_port_io #(
      .NPORTS      (NPORTS),
      .SEL_W       (SEL_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_io (
      .clk           (clk),
      .rst_n         (rst_n),
      .sel           (ctrl_q.sel),
      .drive_low     (drive_low),
      .spu           (ctrl_q.spu),
      .pwr_en        (ctrl_q.pwr_en[NPORTS-1:0]),
      .line_in       (line_in),
      .line_pull_low (line_pull_low),
      .line_pwr      (line_pwr),
      .level         (level)
   );
endmodule

// File: rtl/owb_master_chk.sv
module owb_master_chk #(
   parameter int NPORTS = 4,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wen,
   input logic [31:0]       bus_wdata,
   input logic              busy,
   input logic [3:0]        sel,
   input logic              ien,
   input logic              irq,
   input logic [NPORTS-1:0] line_pull_low,
   input logic [NPORTS-1:0] line_pwr
);
   p_lines_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (line_pull_low == '0));

   p_one_line_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(line_pull_low) <= 1);

   p_pwr_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pull_low & line_pwr) == '0);

   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == '0 && bus_wdata[3] && !busy) |=> busy);

   p_irq_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && ien) |-> irq);

   p_no_irq_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien && !irq) |=> !irq);

   p_busy_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wen && bus_addr == '0) |=> $stable(sel));
endmodule

bind owb_master owb_master_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_addr      (bus_addr),
   .bus_wen       (bus_wen),
   .bus_wdata     (bus_wdata),
   .busy          (busy),
   .sel           (ctrl_q.sel),
   .ien           (ctrl_q.ien),
   .irq           (irq_q),
   .line_pull_low (line_pull_low),
   .line_pwr      (line_pwr)
);

// File: tb/sim_owb_master.sv
`timescale 1ns/1ps
module sim_owb_master;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic          bus_wen = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq;
   logic [NP-1:0] line_pull_low, line_pwr, line_in, dev_low = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   assign line_in = ~(line_pull_low | dev_low);

   owb_master u0 (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wen (bus_wen),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq),
      .line_pull_low (line_pull_low), .line_pwr (line_pwr), .line_in (line_in)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0; bus_addr = 3'h0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      bus_addr = 3'h0;
   endtask

   // counts cycles from the middle of the first cycle after the write edge
   task automatic run_op(input logic [31:0] csr, input int port,
                         output int n_busy, output int n_low, output int n_other,
                         output int n_overlap);
      n_busy = 0; n_low = 0; n_other = 0; n_overlap = 0;
      wr(3'h0, csr);
      while (bus_rdata[3] && n_busy < 20000) begin
         n_busy++;
         for (int p = 0; p < NP; p++) begin
            if (line_pull_low[p] && p == port) n_low++;
            if (line_pull_low[p] && p != port) n_other++;
            if (line_pull_low[p] && line_pwr[p]) n_overlap++;
         end
         @(negedge clk);
      end
   endtask

   task automatic wait_idle();
      int guard = 0;
      @(negedge clk);
      while (bus_rdata[3] && guard < 20000) begin
         guard++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd(3'h0, v); chk("R1 ctrl after reset", v, 32'h0);
      rd(3'h4, v); chk("R1 divider after reset", v, 32'h003E_0138);
      chk("R1 lines released", {28'h0, line_pull_low}, 32'h0);
      chk("R1 pullups off", {28'h0, line_pwr}, 32'h0);
      chk("R1 irq low", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(3'h4, 32'h0001_0003);
      rd(3'h4, v); chk("R2 divider readback", v, 32'h0001_0003);
      // pwr enable line0, sel 2, ien, spu, ovd, rst, dat; bits 5,15:12 set but read 0
      wr(3'h0, 32'h0001_F2B7);
      rd(3'h0, v); chk("R2 ctrl readback", v, 32'h0001_0297);
      chk("R10 pullups line0 by enable, line2 by select", {28'h0, line_pwr}, 32'h5);
      wr(3'h0, 32'h0);
   endtask

   task automatic t_slots();
      int nb, nl, no, nv;
      logic [31:0] v;
      wr(3'h4, 32'h0000_0001);
      run_op(32'h0001_0008, 0, nb, nl, no, nv);
      chk("R3 write-0 slot busy clocks", nb, 140);
      chk("R4 write-0 low clocks", nl, 120);
      chk("R10 no pullup while low", nv, 0);
      rd(3'h0, v); chk("R5 write-0 reads 0", {31'h0, v[0]}, 32'h0);
      chk("R10 pullup back after slot", {31'h0, line_pwr[0]}, 32'h1);
      run_op(32'h0000_0009, 0, nb, nl, no, nv);
      chk("R3 write-1 slot busy clocks", nb, 140);
      chk("R4 write-1 low clocks", nl, 12);
      rd(3'h0, v); chk("R5 write-1 idle line reads 1", {31'h0, v[0]}, 32'h1);
      dev_low[0] = 1'b1;
      run_op(32'h0000_0009, 0, nb, nl, no, nv);
      rd(3'h0, v); chk("R5 read slot device low reads 0", {31'h0, v[0]}, 32'h0);
      dev_low[0] = 1'b0;
      chk("R9 no line low when idle", {28'h0, line_pull_low}, 32'h0);
   endtask

   // with reload 0, sample uses line level of clock 12 after the write edge
   task automatic t_sample_edge(input int k, input logic exp);
      logic [31:0] v;
      wr(3'h4, 32'h0);
      dev_low[0] = 1'b1;
      @(negedge clk);
      bus_addr = 3'h0; bus_wdata = 32'h9; bus_wen = 1'b1;
      @(posedge clk);
      #1 bus_wen = 1'b0;
      repeat (k) @(posedge clk);
      #1 dev_low[0] = 1'b0;
      wait_idle();
      rd(3'h0, v);
      chk($sformatf("R5 sample point release at clock %0d", k), {31'h0, v[0]}, {31'h0, exp});
   endtask

   task automatic t_bus_reset();
      int nb, nl, no, nv;
      logic [31:0] v;
      wr(3'h4, 32'h0);
      dev_low[1] = 1'b1;
      run_op(32'h0000_010A, 1, nb, nl, no, nv);
      chk("R6 reset busy clocks", nb, 960);
      chk("R6 reset low clocks", nl, 480);
      rd(3'h0, v); chk("R6 presence reads 0", {31'h0, v[0]}, 32'h0);
      dev_low[1] = 1'b0;
      run_op(32'h0000_010A, 1, nb, nl, no, nv);
      rd(3'h0, v); chk("R6 no device reads 1", {31'h0, v[0]}, 32'h1);
   endtask

   task automatic t_overdrive();
      int nb, nl, no, nv;
      wr(3'h4, 32'h0000_0003);
      run_op(32'h0000_000C, 0, nb, nl, no, nv);
      chk("R7 overdrive busy clocks", nb, 70);
      chk("R7 overdrive low clocks", nl, 60);
      run_op(32'h0000_0008, 0, nb, nl, no, nv);
      chk("R7 normal busy clocks", nb, 280);
      chk("R7 normal low clocks", nl, 240);
   endtask

   task automatic t_ports();
      int nb, nl, no, nv;
      logic [31:0] v;
      wr(3'h4, 32'h0);
      run_op(32'h0000_0308, 3, nb, nl, no, nv);
      chk("R8 line3 low clocks", nl, 60);
      chk("R8 other lines untouched", no, 0);
      dev_low = '1;
      run_op(32'h0000_0909, 9, nb, nl, no, nv);
      chk("R8 out-of-range select busy", nb, 70);
      chk("R8 out-of-range select drives none", no, 0);
      rd(3'h0, v); chk("R8 out-of-range select reads 1", {31'h0, v[0]}, 32'h1);
      dev_low = '0;
   endtask

   task automatic t_irq();
      int nb, nl, no, nv;
      logic [31:0] v;
      run_op(32'h0000_0089, 0, nb, nl, no, nv);
      chk("R11 irq set at end", {31'h0, irq}, 32'h1);
      rd(3'h0, v); chk("R11 flag bit 6 set", {31'h0, v[6]}, 32'h1);
      wr(3'h0, 32'h0000_0080);
      chk("R11 irq cleared by write", {31'h0, irq}, 32'h0);
      run_op(32'h0000_0009, 0, nb, nl, no, nv);
      chk("R11 no irq when disabled", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      wr(3'h4, 32'h0);
      wr(3'h0, 32'h0000_0009);
      wr(3'h0, 32'h0000_02FF);
      wr(3'h4, 32'h0000_0005);
      wait_idle();
      rd(3'h0, v); chk("R12 ctrl write while busy ignored", v, 32'h0000_0001);
      rd(3'h4, v); chk("R12 divider write while busy ignored", v, 32'h0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_regmap();
      t_slots();
      t_sample_edge(12, 1'b1);
      t_sample_edge(13, 1'b0);
      t_bus_reset();
      t_overdrive();
      t_ports();
      t_irq();
      t_busy_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule